// File: doc/BRIEF.md
# Debug Address Match Comparator Bank

This block holds a set of programmable instruction-breakpoint slots and data-watchpoint slots. Each slot has a value register (an aligned address) and a control register (enable, privilege level, access direction and a per-byte select mask). Software programs the slots through a small indexed register port. While the core runs, the bank compares every retiring program counter and every data access against the enabled slots. It reports a breakpoint or watchpoint hit, together with the slot that matched, one cycle later.

Breakpoint slots match on a 4-byte-aligned base address. Watchpoint slots match on an 8-byte-aligned base address. In both cases the low address bits select one bit of the byte mask, so a watchpoint can cover 1, 2, 4 or 8 bytes. A read-only identity word reports how many slots of each kind are built. A sticky per-slot vector records every slot that has matched since its control register was last written.

Top module: `dbg_match_bank`

## Requirements
- R1: A breakpoint slot matches a valid fetch when its value register equals `pc` with bits [1:0] forced to zero, and mask bit `ctrl[4 + pc[1:0]]` is set (breakpoint mask in ctrl[7:4]).
- R2: A watchpoint slot matches a valid data access when its value register equals `da_addr` with bits [2:0] forced to zero, and mask bit `ctrl[4 + da_addr[2:0]]` is set (watchpoint mask in ctrl[11:4]).
- R3: A load (`da_store`=0) matches only watchpoint slots with ctrl[2] (load enable) set. A store (`da_store`=1) matches only slots with ctrl[3] (store enable) set.
- R4: ctrl[1] selects the privilege level a slot responds to (0 = EL0, 1 = EL1). A slot never matches an access made at the other level.
- R5: ctrl[0] is the slot enable. A slot whose control register is written with zero never matches.
- R6: Select code 4 reads the identity word: bits [15:12] hold N_BP-1, bits [23:20] hold N_WP-1, and every other bit is zero. Writes to it have no effect.
- R7: When several slots of one kind match in the same cycle, the reported index is the lowest-numbered matching slot.
- R8: The sticky vectors `bp_sticky`/`wp_sticky` set the bit of every matching slot and keep it until that slot's control register is written.
- R9: An access to an unimplemented slot index, or to select codes 5 to 7, reads zero, changes no register and pulses `reg_err` in the following cycle.
- R10: `bp_hit`/`wp_hit` and their indices are registered: they reflect the access presented in the previous cycle and are low after a cycle with no match.
- R11: Value registers read back in full. Control registers read back their implemented bits (8 for breakpoints, 12 for watchpoints), and the upper bits read as zero. Select codes: 0 breakpoint value, 1 breakpoint control, 2 watchpoint value, 3 watchpoint control.
- R12: After a synchronous reset, all hits, sticky bits, `reg_rdata` and `reg_err` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_en | input | 1 | Register port access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_sel | input | 3 | Register kind select (0..4) |
| reg_idx | input | 4 | Slot index |
| reg_wdata | input | AW | Write data |
| reg_rdata | output | AW | Registered read data |
| reg_err | output | 1 | Pulse: previous access was to an unimplemented register |
| pc_valid | input | 1 | Retiring instruction present |
| pc | input | AW | Retiring program counter |
| pc_el | input | 1 | Privilege of the fetch (0 EL0, 1 EL1) |
| da_valid | input | 1 | Data access present |
| da_addr | input | AW | Data address |
| da_store | input | 1 | 1 = store, 0 = load |
| da_el | input | 1 | Privilege of the data access |
| bp_hit | output | 1 | Breakpoint matched |
| bp_idx | output | 4 | Lowest matching breakpoint slot |
| bp_sticky | output | N_BP | Sticky breakpoint match vector |
| wp_hit | output | 1 | Watchpoint matched |
| wp_idx | output | 4 | Lowest matching watchpoint slot |
| wp_sticky | output | N_WP | Sticky watchpoint match vector |

## Verification
The bench builds the bank with four breakpoint slots and two watchpoint slots, at a 32-bit address width. Because the two counts differ, the identity word shows that each field carries its own count. The narrow watchpoint bank also leaves indices 2 to 15 unimplemented while the same indices are still legal for breakpoints. This brings the error path within reach, including the case where a truncated index would alias onto slot 0. Two breakpoint slots programmed identically exercise the lowest-index rule, and two watchpoint slots with different direction enables exercise load/store filtering.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  localparam int IDX_W   = 4;
  localparam int CTL_EN  = 0;
  localparam int CTL_EL  = 1;
  localparam int CTL_LD  = 2;
  localparam int CTL_ST  = 3;
  localparam int CTL_MSK = 4;
  localparam int ID_BP_LSB = 12;
  localparam int ID_WP_LSB = 20;

  typedef enum logic [2:0] {
    SEL_BVAL = 3'd0,
    SEL_BCTL = 3'd1,
    SEL_WVAL = 3'd2,
    SEL_WCTL = 3'd3,
    SEL_ID   = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/dbg_slot_file.sv
module dbg_slot_file import dbg_pkg::*; #(
  parameter int N  = 4,
  parameter int AW = 32,
  parameter int CW = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_val,
  input  logic                   wr_ctl,
  input  logic [IDX_W-1:0]       idx,
  input  logic [AW-1:0]          wdata,
  output logic [N-1:0][AW-1:0]   val_q,
  output logic [N-1:0][CW-1:0]   ctl_q,
  output logic [N-1:0]           ctl_wr,
  output logic                   idx_ok,
  output logic [AW-1:0]          rd_val,
  output logic [CW-1:0]          rd_ctl
);
  for (genvar i = 0; i < N; i++) begin : g_slot
    logic          sel;
    logic [AW-1:0] val_r;
    logic [CW-1:0] ctl_r;
    assign sel       = (idx == IDX_W'(i));
    assign ctl_wr[i] = wr_ctl & sel;
    always_ff @(posedge clk) begin
      if (rst) begin
        val_r <= '0;
        ctl_r <= '0;
      end else begin
        if (wr_val && sel) val_r <= wdata;
        if (ctl_wr[i])     ctl_r <= wdata[CW-1:0];
      end
    end
    assign val_q[i] = val_r;
    assign ctl_q[i] = ctl_r;
  end

  always_comb begin
    idx_ok = 1'b0;
    rd_val = '0;
    rd_ctl = '0;
    for (int i = 0; i < N; i++) begin
      if (idx == IDX_W'(i)) begin
        idx_ok = 1'b1;
        rd_val = val_q[i];
        rd_ctl = ctl_q[i];
      end
    end
  end
endmodule

// File: rtl/dbg_cmp_array.sv
module dbg_cmp_array import dbg_pkg::*; #(
  parameter int N         = 4,
  parameter int AW        = 32,
  parameter int LOW_W     = 2,
  parameter bit CHECK_DIR = 1'b0,
  localparam int MSK_W    = 1 << LOW_W,
  localparam int CW       = CTL_MSK + MSK_W
) (
  input  logic                 valid,
  input  logic [AW-1:0]        addr,
  input  logic                 el,
  input  logic                 store,
  input  logic [N-1:0][AW-1:0] val_q,
  input  logic [N-1:0][CW-1:0] ctl_q,
  output logic [N-1:0]         match
);
  logic [AW-1:0]    base;
  logic [LOW_W-1:0] lane;
  assign base = {addr[AW-1:LOW_W], {LOW_W{1'b0}}};
  assign lane = addr[LOW_W-1:0];

  for (genvar i = 0; i < N; i++) begin : g_cmp
    logic [MSK_W-1:0] msk;
    logic             dir_ok;
    assign msk    = ctl_q[i][CTL_MSK +: MSK_W];
    assign dir_ok = (CHECK_DIR == 1'b0) ||
                    (store ? ctl_q[i][CTL_ST] : ctl_q[i][CTL_LD]);
    assign match[i] = valid & ctl_q[i][CTL_EN] & (ctl_q[i][CTL_EL] == el) &
                      (val_q[i] == base) & msk[lane] & dir_ok;
  end
endmodule

// File: rtl/dbg_first_set.sv
module dbg_first_set import dbg_pkg::*; #(
  parameter int N = 4
) (
  input  logic [N-1:0]     vec,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/dbg_match_bank.sv
module dbg_match_bank import dbg_pkg::*; #(
  parameter int AW   = 32,
  parameter int N_BP = 4,
  parameter int N_WP = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_en,
  input  logic             reg_wr,
  input  logic [2:0]       reg_sel,
  input  logic [IDX_W-1:0] reg_idx,
  input  logic [AW-1:0]    reg_wdata,
  output logic [AW-1:0]    reg_rdata,
  output logic             reg_err,
  input  logic             pc_valid,
  input  logic [AW-1:0]    pc,
  input  logic             pc_el,
  input  logic             da_valid,
  input  logic [AW-1:0]    da_addr,
  input  logic             da_store,
  input  logic             da_el,
  output logic             bp_hit,
  output logic [IDX_W-1:0] bp_idx,
  output logic [N_BP-1:0]  bp_sticky,
  output logic             wp_hit,
  output logic [IDX_W-1:0] wp_idx,
  output logic [N_WP-1:0]  wp_sticky
);
  localparam int BP_LOW = 2;
  localparam int WP_LOW = 3;
  localparam int BCW = CTL_MSK + (1 << BP_LOW);
  localparam int WCW = CTL_MSK + (1 << WP_LOW);
  localparam logic [AW-1:0] ID_WORD = (AW'(N_BP - 1) << ID_BP_LSB) |
                                      (AW'(N_WP - 1) << ID_WP_LSB);

  logic wr_any;
  assign wr_any = reg_en & reg_wr;

  logic [N_BP-1:0][AW-1:0]  b_val;
  logic [N_BP-1:0][BCW-1:0] b_ctl;
  logic [N_BP-1:0]          b_cwr;
  logic                     b_ok;
  logic [AW-1:0]            b_rval;
  logic [BCW-1:0]           b_rctl;

  dbg_slot_file #(.N(N_BP), .AW(AW), .CW(BCW)) u_bp_regs (
    .clk, .rst,
    .wr_val (wr_any && reg_sel == SEL_BVAL),
    .wr_ctl (wr_any && reg_sel == SEL_BCTL),
    .idx    (reg_idx), .wdata(reg_wdata),
    .val_q  (b_val), .ctl_q(b_ctl), .ctl_wr(b_cwr),
    .idx_ok (b_ok), .rd_val(b_rval), .rd_ctl(b_rctl)
  );

  logic [N_WP-1:0][AW-1:0]  w_val;
  logic [N_WP-1:0][WCW-1:0] w_ctl;
  logic [N_WP-1:0]          w_cwr;
  logic                     w_ok;
  logic [AW-1:0]            w_rval;
  logic [WCW-1:0]           w_rctl;

  dbg_slot_file #(.N(N_WP), .AW(AW), .CW(WCW)) u_wp_regs (
    .clk, .rst,
    .wr_val (wr_any && reg_sel == SEL_WVAL),
    .wr_ctl (wr_any && reg_sel == SEL_WCTL),
    .idx    (reg_idx), .wdata(reg_wdata),
    .val_q  (w_val), .ctl_q(w_ctl), .ctl_wr(w_cwr),
    .idx_ok (w_ok), .rd_val(w_rval), .rd_ctl(w_rctl)
  );

  logic [N_BP-1:0] bp_m;
  logic [N_WP-1:0] wp_m;

  dbg_cmp_array #(.N(N_BP), .AW(AW), .LOW_W(BP_LOW), .CHECK_DIR(1'b0)) u_bp_cmp (
    .valid(pc_valid), .addr(pc), .el(pc_el), .store(1'b0),
    .val_q(b_val), .ctl_q(b_ctl), .match(bp_m)
  );

  dbg_cmp_array #(.N(N_WP), .AW(AW), .LOW_W(WP_LOW), .CHECK_DIR(1'b1)) u_wp_cmp (
    .valid(da_valid), .addr(da_addr), .el(da_el), .store(da_store),
    .val_q(w_val), .ctl_q(w_ctl), .match(wp_m)
  );

  logic [IDX_W-1:0] bp_first, wp_first;
  dbg_first_set #(.N(N_BP)) u_bp_first (.vec(bp_m), .idx(bp_first));
  dbg_first_set #(.N(N_WP)) u_wp_first (.vec(wp_m), .idx(wp_first));

  logic [AW-1:0] rd_next;
  logic          bad;
  always_comb begin
    rd_next = '0;
    bad     = 1'b0;
    case (reg_sel)
      SEL_BVAL: begin bad = !b_ok; rd_next = b_rval;      end
      SEL_BCTL: begin bad = !b_ok; rd_next = AW'(b_rctl); end
      SEL_WVAL: begin bad = !w_ok; rd_next = w_rval;      end
      SEL_WCTL: begin bad = !w_ok; rd_next = AW'(w_rctl); end
      SEL_ID:   rd_next = ID_WORD;
      default:  bad = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      reg_err   <= 1'b0;
      bp_hit    <= 1'b0;
      bp_idx    <= '0;
      bp_sticky <= '0;
      wp_hit    <= 1'b0;
      wp_idx    <= '0;
      wp_sticky <= '0;
    end else begin
      reg_err <= reg_en & bad;
      if (reg_en && bad)          reg_rdata <= '0;
      else if (reg_en && !reg_wr) reg_rdata <= rd_next;
      bp_hit    <= |bp_m;
      bp_idx    <= bp_first;
      bp_sticky <= (bp_sticky & ~b_cwr) | bp_m;
      wp_hit    <= |wp_m;
      wp_idx    <= wp_first;
      wp_sticky <= (wp_sticky & ~w_cwr) | wp_m;
    end
  end
endmodule

// File: rtl/dbg_match_bank_chk.sv
module dbg_match_bank_chk #(
  parameter int AW   = 32,
  parameter int N_BP = 4,
  parameter int N_WP = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            reg_en,
  input logic            reg_wr,
  input logic [AW-1:0]   reg_rdata,
  input logic            reg_err,
  input logic            pc_valid,
  input logic            da_valid,
  input logic            bp_hit,
  input logic [3:0]      bp_idx,
  input logic [N_BP-1:0] bp_sticky,
  input logic            wp_hit,
  input logic [3:0]      wp_idx,
  input logic [N_WP-1:0] wp_sticky
);
  assert_bp_idx_range_R7: assert property (@(posedge clk) disable iff (rst)
    bp_hit |-> (int'(bp_idx) < N_BP));
  assert_wp_idx_range_R7: assert property (@(posedge clk) disable iff (rst)
    wp_hit |-> (int'(wp_idx) < N_WP));
  assert_bp_sticky_set_R8: assert property (@(posedge clk) disable iff (rst)
    bp_hit |-> |(bp_sticky & (N_BP'(1) << bp_idx)));
  assert_wp_sticky_set_R8: assert property (@(posedge clk) disable iff (rst)
    wp_hit |-> |(wp_sticky & (N_WP'(1) << wp_idx)));
  assert_bp_sticky_keep_R8: assert property (@(posedge clk) disable iff (rst)
    !(reg_en && reg_wr) |=> ((bp_sticky & $past(bp_sticky)) == $past(bp_sticky)));
  assert_wp_sticky_keep_R8: assert property (@(posedge clk) disable iff (rst)
    !(reg_en && reg_wr) |=> ((wp_sticky & $past(wp_sticky)) == $past(wp_sticky)));
  assert_bp_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !pc_valid |=> !bp_hit);
  assert_wp_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !da_valid |=> !wp_hit);
  assert_err_zero_R9: assert property (@(posedge clk) disable iff (rst)
    reg_err |-> (reg_rdata == '0));
  assert_err_cause_R9: assert property (@(posedge clk) disable iff (rst)
    !reg_en |=> !reg_err);
endmodule

bind dbg_match_bank dbg_match_bank_chk #(.AW(AW), .N_BP(N_BP), .N_WP(N_WP)) u_chk (.*);

// File: tb/tb_dbg_match_bank.sv
module tb_dbg_match_bank;
  localparam int AW = 32;
  localparam int N_BP = 4;
  localparam int N_WP = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_en = 1'b0, reg_wr = 1'b0;
  logic [2:0] reg_sel = '0;
  logic [3:0] reg_idx = '0;
  logic [AW-1:0] reg_wdata = '0;
  logic [AW-1:0] reg_rdata;
  logic reg_err;
  logic pc_valid = 1'b0, pc_el = 1'b0;
  logic [AW-1:0] pc = '0;
  logic da_valid = 1'b0, da_store = 1'b0, da_el = 1'b0;
  logic [AW-1:0] da_addr = '0;
  logic bp_hit, wp_hit;
  logic [3:0] bp_idx, wp_idx;
  logic [N_BP-1:0] bp_sticky;
  logic [N_WP-1:0] wp_sticky;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dbg_match_bank #(.AW(AW), .N_BP(N_BP), .N_WP(N_WP)) dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic [2:0] sel, input logic [3:0] idx,
                     input logic [31:0] data, output logic [31:0] rd, output logic er);
    @(negedge clk);
    reg_en = 1'b1; reg_wr = wr; reg_sel = sel; reg_idx = idx; reg_wdata = data;
    @(negedge clk);
    rd = reg_rdata; er = reg_err;
    reg_en = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic wr(input logic [2:0] sel, input logic [3:0] idx, input logic [31:0] data);
    logic [31:0] d; logic e;
    acc(1'b1, sel, idx, data, d, e);
  endtask

  task automatic fetch(input logic [31:0] a, input logic el, output logic h, output logic [3:0] i);
    @(negedge clk);
    pc_valid = 1'b1; pc = a; pc_el = el;
    @(negedge clk);
    h = bp_hit; i = bp_idx;
    pc_valid = 1'b0;
  endtask

  task automatic daccess(input logic [31:0] a, input logic st, input logic el,
                         output logic h, output logic [3:0] i);
    @(negedge clk);
    da_valid = 1'b1; da_addr = a; da_store = st; da_el = el;
    @(negedge clk);
    h = wp_hit; i = wp_idx;
    da_valid = 1'b0;
  endtask

  function automatic logic [31:0] mkb(input logic en, input logic el, input logic [3:0] m);
    return {24'd0, m, 2'b00, el, en};
  endfunction

  function automatic logic [31:0] mkw(input logic en, input logic el, input logic ld,
                                      input logic st, input logic [7:0] m);
    return {20'd0, m, st, ld, el, en};
  endfunction

  task automatic t_reset;
    chk("R12 bp_hit", {31'd0, bp_hit}, 32'd0);
    chk("R12 wp_hit", {31'd0, wp_hit}, 32'd0);
    chk("R12 sticky", {26'd0, wp_sticky, bp_sticky}, 32'd0);
    chk("R12 rdata/err", reg_rdata | {31'd0, reg_err}, 32'd0);
  endtask

  task automatic t_id;
    logic [31:0] d; logic e;
    acc(1'b0, 3'd4, 4'd0, 32'd0, d, e);
    chk("R6 id word", d, 32'h0010_3000);
    wr(3'd4, 4'd0, 32'hFFFF_FFFF);
    acc(1'b0, 3'd4, 4'd0, 32'd0, d, e);
    chk("R6 id after write", d, 32'h0010_3000);
  endtask

  task automatic t_readback;
    logic [31:0] d; logic e;
    wr(3'd0, 4'd1, 32'h1000_0100);
    acc(1'b0, 3'd0, 4'd1, 32'd0, d, e);
    chk("R11 bp value", d, 32'h1000_0100);
    wr(3'd1, 4'd3, 32'hFFFF_FFF2);
    acc(1'b0, 3'd1, 4'd3, 32'd0, d, e);
    chk("R11 bp ctrl width", d, 32'h0000_00F2);
    wr(3'd1, 4'd3, 32'd0);
    wr(3'd3, 4'd1, 32'hFFFF_FFF2);
    acc(1'b0, 3'd3, 4'd1, 32'd0, d, e);
    chk("R11 wp ctrl width", d, 32'h0000_0FF2);
    wr(3'd3, 4'd1, 32'd0);
  endtask

  task automatic t_bp;
    logic h; logic [3:0] i;
    wr(3'd1, 4'd1, mkb(1'b1, 1'b0, 4'b0100));
    fetch(32'h1000_0102, 1'b0, h, i);
    chk("R1 bp hit", {27'd0, i, h}, {27'd0, 4'd1, 1'b1});
    @(negedge clk);
    chk("R10 bp hit drops", {31'd0, bp_hit}, 32'd0);
    chk("R8 bp sticky", {28'd0, bp_sticky}, 32'h2);
    fetch(32'h1000_0100, 1'b0, h, i);
    chk("R1 mask lane0 clear", {31'd0, h}, 32'd0);
    fetch(32'h1000_0103, 1'b0, h, i);
    chk("R1 mask lane3 clear", {31'd0, h}, 32'd0);
    fetch(32'h1000_0106, 1'b0, h, i);
    chk("R1 other base", {31'd0, h}, 32'd0);
    fetch(32'h1000_0102, 1'b1, h, i);
    chk("R4 bp wrong level", {31'd0, h}, 32'd0);
    wr(3'd1, 4'd1, 32'd0);
    chk("R8 sticky cleared by ctrl write", {28'd0, bp_sticky}, 32'd0);
    fetch(32'h1000_0102, 1'b0, h, i);
    chk("R5 disabled slot", {31'd0, h}, 32'd0);
  endtask

  task automatic t_bp_prio;
    logic h; logic [3:0] i;
    wr(3'd0, 4'd0, 32'h2000_0000);
    wr(3'd0, 4'd2, 32'h2000_0000);
    wr(3'd1, 4'd0, mkb(1'b1, 1'b1, 4'b0001));
    wr(3'd1, 4'd2, mkb(1'b1, 1'b1, 4'b0001));
    fetch(32'h2000_0000, 1'b1, h, i);
    chk("R7 lowest bp index", {27'd0, i, h}, {27'd0, 4'd0, 1'b1});
    chk("R8 both sticky", {28'd0, bp_sticky}, 32'h5);
    wr(3'd1, 4'd0, 32'd0);
    fetch(32'h2000_0000, 1'b1, h, i);
    chk("R7 next bp index", {27'd0, i, h}, {27'd0, 4'd2, 1'b1});
    chk("R8 sticky after clear", {28'd0, bp_sticky}, 32'h4);
  endtask

  task automatic t_wp;
    logic h; logic [3:0] i;
    wr(3'd2, 4'd0, 32'h3000_0008);
    wr(3'd3, 4'd0, mkw(1'b1, 1'b0, 1'b1, 1'b0, 8'b0011_0000));
    daccess(32'h3000_000C, 1'b0, 1'b0, h, i);
    chk("R2 wp load hit", {27'd0, i, h}, {27'd0, 4'd0, 1'b1});
    daccess(32'h3000_000E, 1'b0, 1'b0, h, i);
    chk("R2 wp lane6 clear", {31'd0, h}, 32'd0);
    daccess(32'h3000_000C, 1'b1, 1'b0, h, i);
    chk("R3 store on load-only", {31'd0, h}, 32'd0);
    wr(3'd2, 4'd1, 32'h3000_0008);
    wr(3'd3, 4'd1, mkw(1'b1, 1'b0, 1'b0, 1'b1, 8'hFF));
    daccess(32'h3000_000F, 1'b1, 1'b0, h, i);
    chk("R3 store-only hit", {27'd0, i, h}, {27'd0, 4'd1, 1'b1});
    daccess(32'h3000_000C, 1'b0, 1'b0, h, i);
    chk("R3 load skips store-only", {27'd0, i, h}, {27'd0, 4'd0, 1'b1});
    wr(3'd3, 4'd1, mkw(1'b1, 1'b0, 1'b1, 1'b1, 8'hFF));
    daccess(32'h3000_000C, 1'b0, 1'b0, h, i);
    chk("R7 lowest wp index", {27'd0, i, h}, {27'd0, 4'd0, 1'b1});
    chk("R8 wp sticky", {30'd0, wp_sticky}, 32'h3);
    daccess(32'h3000_000C, 1'b0, 1'b1, h, i);
    chk("R4 wp wrong level", {31'd0, h}, 32'd0);
  endtask

  task automatic t_bad_idx;
    logic [31:0] d; logic e;
    acc(1'b1, 3'd0, 4'd5, 32'h1234_5678, d, e);
    chk("R9 bad write err", {31'd0, e}, 32'd1);
    acc(1'b0, 3'd0, 4'd5, 32'd0, d, e);
    chk("R9 bad read data", d, 32'd0);
    chk("R9 bad read err", {31'd0, e}, 32'd1);
    acc(1'b1, 3'd2, 4'd2, 32'hDEAD_0000, d, e);
    chk("R9 wp idx2 err", {31'd0, e}, 32'd1);
    acc(1'b0, 3'd2, 4'd0, 32'd0, d, e);
    chk("R9 slot0 untouched", d, 32'h3000_0008);
    chk("R9 good read no err", {31'd0, e}, 32'd0);
    acc(1'b0, 3'd5, 4'd0, 32'd0, d, e);
    chk("R9 bad select", {d[30:0], e}, 32'd1);
    acc(1'b0, 3'd3, 4'd15, 32'd0, d, e);
    chk("R9 wp idx15", {d[30:0], e}, 32'd1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_id();
    t_readback();
    t_bp();
    t_bp_prio();
    t_wp();
    t_bad_idx();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule